// File: doc/BRIEF.md
# Frame Length Trimmer for a Transmit Word Path

This block sits between a bus-side write path and an Ethernet transmit FIFO. Software first programs the true byte length of a frame. It then streams the frame as 32-bit or 64-bit words. Each bus path may round the frame up to its own word boundary, so the tail of a frame can carry several bytes of padding, or even whole words of it. The block counts the bytes it forwards against the programmed length. It passes exactly that many bytes to the FIFO and drops everything after them. Each FIFO beat is 32 bits wide and carries a per-byte keep mask. The final beat is marked.

A 64-bit write leaves the block as two FIFO beats, lower half first. While the upper half is going out, the block lowers its ready for one cycle. Byte 0 of the frame is carried in data bits 7:0. Keep bit i qualifies data bits 8i+7:8i. Lanes outside the keep mask are driven to zero, so padding values never appear downstream.

The control is a four-state machine:
- **ST_IDLE** is the state after reset. Data is accepted and discarded.
- **ST_PASS** counts and forwards bytes.
- **ST_UPPER** emits the held upper half of a wide word.
- **ST_DISCARD** swallows data once the length is used up.

The transitions are:
- A length write moves any state to ST_PASS. If the length is zero it moves to ST_DISCARD instead.
- ST_PASS moves to ST_UPPER on a wide word whose lower half does not end the frame.
- ST_PASS moves to ST_DISCARD on the word that ends the frame.
- ST_UPPER moves to ST_DISCARD if the upper half ends the frame, and otherwise back to ST_PASS.

Top module: `frame_len_trimmer`

## Requirements
- R1: After synchronous reset, push_valid and push_last are 0 and wr_ready is 1. Data words written before any length write produce no FIFO push.
- R2: After a length write of N, exactly the first N bytes of the following data reach the FIFO. No byte beyond N is ever pushed, for example N=0x5D4 with 0x5D8 bytes written.
- R3: A narrow write (wr_wide=0) is forwarded as one beat. Frame byte 4b+i appears in push_data[8i+7:8i] of beat b.
- R4: A wide write (wr_wide=1) is forwarded as two consecutive beats. The beat from wr_data[31:0] comes first, and wr_ready is 0 during the cycle after the wide word is accepted when its upper half is still needed.
- R5: push_last is 1 on the final beat of a frame only. On every other beat push_keep is 4'b1111.
- R6: When N is not a multiple of 4, the final beat has push_keep bits 0 to (N-1) mod 4 set. Lanes outside push_keep are zero. The last genuine byte is always kept.
- R7: Words, or upper halves of wide words, that arrive after the length is exhausted are accepted and discarded, however many of them there are.
- R8: A length write of zero produces no FIFO push for the data that follows.
- R9: A length write in any state restarts counting with the new length. A data word presented in the same cycle as a length write is dropped.
- R10: A beat appears on the push outputs in the cycle after the word is accepted. The upper beat of a wide word follows one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| len_wr | input | 1 | Length register write strobe |
| len_value | input | LEN_W | Frame length in bytes |
| wr_valid | input | 1 | Data word write strobe |
| wr_wide | input | 1 | 1: 64-bit word, 0: 32-bit word in bits 31:0 |
| wr_data | input | 2*BEAT_W | Data word, frame byte order little-endian |
| wr_ready | output | 1 | Word accepted when high together with wr_valid |
| push_valid | output | 1 | FIFO push strobe |
| push_data | output | BEAT_W | FIFO beat data, masked lanes zero |
| push_keep | output | BEAT_W/8 | Byte-valid mask of the beat |
| push_last | output | 1 | Final beat of the frame |

## Verification
The bench builds the block with LEN_W=12 and the default 32-bit beat. Twelve bits are enough for a full-size 0x5D4-byte frame written through the 64-bit path with trailing padding. With 4-byte beats, every residue of the length modulo 4 and modulo 8 can be reached with short frames. That covers a frame ending in the lower half of a wide word, a frame ending in the upper half, and whole padding words after the end.

// File: rtl/trim_pkg.sv
package trim_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PASS    = 2'd1,
        ST_UPPER   = 2'd2,
        ST_DISCARD = 2'd3
    } trim_state_e;
endpackage

// File: rtl/trim_mask_gen.sv
// Derives the keep mask and the end-of-frame flag from the remaining byte count.
module trim_mask_gen #(
    parameter int LEN_W      = 16,
    parameter int BEAT_BYTES = 4
) (
    input  logic [LEN_W-1:0]      rem_i,
    output logic [BEAT_BYTES-1:0] keep_o,
    output logic                  final_o
);
    localparam logic [LEN_W-1:0] BEAT_LEN = LEN_W'(BEAT_BYTES);

    // At-or-below comparison: covers straddling words and exact fits alike.
    assign final_o = (rem_i <= BEAT_LEN);

    for (genvar g = 0; g < BEAT_BYTES; g++) begin : g_lane
        localparam logic [LEN_W-1:0] LANE_IDX = LEN_W'(g);
        assign keep_o[g] = (rem_i > LANE_IDX);
    end
endmodule

// File: rtl/trim_remaining.sv
// Remaining-bytes counter, loaded by a length write, reduced per forwarded beat.
module trim_remaining #(
    parameter int LEN_W      = 16,
    parameter int BEAT_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [LEN_W-1:0] load_val_i,
    input  logic             consume_i,
    input  logic             final_i,
    output logic [LEN_W-1:0] rem_o
);
    localparam logic [LEN_W-1:0] BEAT_LEN = LEN_W'(BEAT_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_o <= '0;
        end else if (load_i) begin
            rem_o <= load_val_i;
        end else if (consume_i) begin
            rem_o <= final_i ? '0 : (rem_o - BEAT_LEN);
        end
    end
endmodule

// File: rtl/trim_fsm.sv
// Control state machine: idle, pass, upper-half emission, discard.
module trim_fsm
    import trim_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic len_wr_i,
    input  logic len_zero_i,
    input  logic wr_valid_i,
    input  logic wr_wide_i,
    input  logic final_i,
    output logic wr_ready_o,
    output logic push_low_o,
    output logic push_high_o,
    output logic hold_upper_o
);
    trim_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (len_wr_i) begin
            state_d = len_zero_i ? ST_DISCARD : ST_PASS;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_PASS: begin
                    if (wr_valid_i) begin
                        if (final_i)        state_d = ST_DISCARD;
                        else if (wr_wide_i) state_d = ST_UPPER;
                        else                state_d = ST_PASS;
                    end
                end
                ST_UPPER:   state_d = final_i ? ST_DISCARD : ST_PASS;
                ST_DISCARD: state_d = ST_DISCARD;
            endcase
        end
    end

    // Output logic
    always_comb begin
        wr_ready_o   = 1'b1;
        push_low_o   = 1'b0;
        push_high_o  = 1'b0;
        hold_upper_o = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_PASS: begin
                push_low_o   = wr_valid_i && !len_wr_i;
                hold_upper_o = wr_valid_i && !len_wr_i && wr_wide_i && !final_i;
            end
            ST_UPPER: begin
                wr_ready_o  = 1'b0;
                push_high_o = !len_wr_i;
            end
            ST_DISCARD: ;
        endcase
    end
endmodule

// File: rtl/frame_len_trimmer.sv
// Forwards only the programmed number of bytes of a padded word stream.
module frame_len_trimmer #(
    parameter int LEN_W  = 16,
    parameter int BEAT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  len_wr,
    input  logic [LEN_W-1:0]      len_value,
    input  logic                  wr_valid,
    input  logic                  wr_wide,
    input  logic [2*BEAT_W-1:0]   wr_data,
    output logic                  wr_ready,
    output logic                  push_valid,
    output logic [BEAT_W-1:0]     push_data,
    output logic [BEAT_W/8-1:0]   push_keep,
    output logic                  push_last
);
    localparam int BEAT_BYTES = BEAT_W / 8;

    logic [LEN_W-1:0]      rem;
    logic [BEAT_BYTES-1:0] keep;
    logic                  final_beat;
    logic                  push_low, push_high, hold_upper, push_now;
    logic [BEAT_W-1:0]     upper_q, beat_raw, beat_clean;

    trim_mask_gen #(.LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)) u_mask (
        .rem_i   (rem),
        .keep_o  (keep),
        .final_o (final_beat)
    );

    trim_remaining #(.LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)) u_rem (
        .clk        (clk),
        .rst        (rst),
        .load_i     (len_wr),
        .load_val_i (len_value),
        .consume_i  (push_now),
        .final_i    (final_beat),
        .rem_o      (rem)
    );

    trim_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .len_wr_i     (len_wr),
        .len_zero_i   (len_value == '0),
        .wr_valid_i   (wr_valid),
        .wr_wide_i    (wr_wide),
        .final_i      (final_beat),
        .wr_ready_o   (wr_ready),
        .push_low_o   (push_low),
        .push_high_o  (push_high),
        .hold_upper_o (hold_upper)
    );

    assign push_now = push_low | push_high;
    assign beat_raw = push_high ? upper_q : wr_data[BEAT_W-1:0];

    // Zero the lanes beyond the frame end so padding never leaves the block.
    for (genvar g = 0; g < BEAT_BYTES; g++) begin : g_clean
        assign beat_clean[8*g +: 8] = keep[g] ? beat_raw[8*g +: 8] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
        end else if (hold_upper) begin
            upper_q <= wr_data[2*BEAT_W-1:BEAT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            push_valid <= 1'b0;
            push_data  <= '0;
            push_keep  <= '0;
            push_last  <= 1'b0;
        end else begin
            push_valid <= push_now;
            push_data  <= beat_clean;
            push_keep  <= push_now ? keep : '0;
            push_last  <= push_now && final_beat;
        end
    end
endmodule

// File: rtl/trim_checker.sv
module trim_checker #(
    parameter int BEAT_BYTES = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  len_wr,
    input logic                  wr_ready,
    input logic                  push_valid,
    input logic [BEAT_BYTES-1:0] push_keep,
    input logic                  push_last
);
    logic seen_len;

    always_ff @(posedge clk) begin
        if (rst)         seen_len <= 1'b0;
        else if (len_wr) seen_len <= 1'b1;
    end

    a_r1_no_push_before_length: assert property (@(posedge clk) disable iff (rst)
        push_valid |-> seen_len);

    a_r4_ready_gap_single: assert property (@(posedge clk) disable iff (rst)
        !wr_ready |=> wr_ready);

    a_r5_last_needs_valid: assert property (@(posedge clk) disable iff (rst)
        push_last |-> push_valid);

    a_r5_full_keep_midframe: assert property (@(posedge clk) disable iff (rst)
        (push_valid && !push_last) |-> (&push_keep));

    a_r6_keep_contiguous: assert property (@(posedge clk) disable iff (rst)
        push_valid |-> ((push_keep != '0) &&
                        ((push_keep & BEAT_BYTES'(push_keep + 1'b1)) == '0)));

    a_r7_quiet_after_last: assert property (@(posedge clk) disable iff (rst)
        push_last |=> !push_valid);
endmodule

bind frame_len_trimmer trim_checker #(.BEAT_BYTES(BEAT_W/8)) u_trim_checker (
    .clk        (clk),
    .rst        (rst),
    .len_wr     (len_wr),
    .wr_ready   (wr_ready),
    .push_valid (push_valid),
    .push_keep  (push_keep),
    .push_last  (push_last)
);

// File: tb/frame_len_trimmer_bench.sv
module frame_len_trimmer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 12;

    typedef struct packed {
        logic [31:0] d;
        logic [3:0]  k;
        logic        l;
    } beat_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             len_wr = 1'b0;
    logic [LEN_W-1:0] len_value = '0;
    logic             wr_valid = 1'b0;
    logic             wr_wide = 1'b0;
    logic [63:0]      wr_data = '0;
    logic             wr_ready, push_valid, push_last;
    logic [31:0]      push_data;
    logic [3:0]       push_keep;

    int vectors = 0;
    int misses  = 0;
    beat_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_len_trimmer #(.LEN_W(LEN_W), .BEAT_W(32)) u_frame_len_trimmer (
        .clk(clk), .rst(rst), .len_wr(len_wr), .len_value(len_value),
        .wr_valid(wr_valid), .wr_wide(wr_wide), .wr_data(wr_data),
        .wr_ready(wr_ready), .push_valid(push_valid), .push_data(push_data),
        .push_keep(push_keep), .push_last(push_last)
    );

    function automatic logic [7:0] pat(int seed, int k);
        return 8'((seed * 29 + k * 11 + 3) & 255);
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare every pushed beat with the scoreboard head.
    always @(negedge clk) begin
        if (!rst && push_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2/R7/R8", "unexpected beat", {push_data, push_keep, push_last}, 0);
            end else begin
                beat_t e;
                e = exp_q.pop_front();
                check({push_data, push_keep, push_last} == e, "R3/R5/R6", "beat data/keep/last",
                      {push_data, push_keep, push_last}, e);
            end
        end
    end

    task automatic write_len(int len);
        @(negedge clk);
        len_wr = 1'b1;
        len_value = LEN_W'(len);
        @(posedge clk);
        #1 len_wr = 1'b0;
    endtask

    task automatic drive_word(bit wide, logic [63:0] d);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1;
        wr_wide  = wide;
        wr_data  = d;
        @(posedge clk);
        #1 wr_valid = 1'b0;
    endtask

    // Driver side of the scoreboard: expected beats from the requirements.
    task automatic expect_frame(int len, int sent, int seed);
        for (int b = 0; (b * 4 < len) && (b * 4 < sent); b++) begin
            beat_t e;
            e = '0;
            for (int i = 0; i < 4; i++) begin
                if (4 * b + i < len) begin
                    e.d[8*i +: 8] = pat(seed, 4 * b + i);
                    e.k[i] = 1'b1;
                end
            end
            e.l = (4 * b + 4 >= len);
            exp_q.push_back(e);
        end
    endtask

    task automatic send_frame(int len, bit wide, int nwords, int seed);
        int wb;
        wb = wide ? 8 : 4;
        write_len(len);
        expect_frame(len, nwords * wb, seed);
        for (int w = 0; w < nwords; w++) begin
            logic [63:0] d;
            d = '0;
            for (int i = 0; i < wb; i++) d[8*i +: 8] = pat(seed, w * wb + i);
            drive_word(wide, d);
            if (wide && (w * 8 + 4 < len)) begin
                check(wr_ready == 1'b0, "R4", "ready low during upper half", wr_ready, 0);
            end
        end
    endtask

    task automatic settle(string req);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, req, "beats outstanding", exp_q.size(), 0);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(push_valid == 1'b0, "R1", "push_valid in reset", push_valid, 0);
        check(wr_ready == 1'b1, "R1", "wr_ready in reset", wr_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        check(push_last == 1'b0, "R1", "push_last after reset", push_last, 0);

        // R1: data before any length write is dropped
        drive_word(1'b0, 64'h0000_0000_dead_beef);
        drive_word(1'b1, 64'h0123_4567_89ab_cdef);
        settle("R1");

        // R2 R3 R7: exact multiple, narrow, two padding words
        send_frame(12, 1'b0, 5, 1);
        settle("R7");

        // R6: narrow, last genuine byte in lane 0
        send_frame(13, 1'b0, 4, 2);
        settle("R6");

        // R2 R4 R7: full-size frame, 64-bit rounding adds four bytes
        send_frame(12'h5D4, 1'b1, 187, 3);
        settle("R2");

        // R4 R6 R10: wide, frame ends in upper half
        send_frame(13, 1'b1, 2, 4);
        settle("R4");

        // R6 R7: wide, short frame plus extra wide padding words
        send_frame(3, 1'b1, 3, 5);
        settle("R6");

        // R8: zero length discards everything
        send_frame(0, 1'b0, 3, 6);
        send_frame(0, 1'b1, 2, 7);
        settle("R8");

        // R9: re-arm in mid-frame, then a new shorter frame
        send_frame(20, 1'b0, 2, 8);
        send_frame(8, 1'b0, 3, 9);
        settle("R9");

        // R9: data word in the same cycle as the length write is dropped
        @(negedge clk);
        len_wr = 1'b1;
        len_value = LEN_W'(6);
        wr_valid = 1'b1;
        wr_wide = 1'b0;
        wr_data = 64'h0000_0000_5a5a_5a5a;
        @(posedge clk);
        #1;
        len_wr = 1'b0;
        wr_valid = 1'b0;
        expect_frame(6, 8, 10);
        for (int w = 0; w < 2; w++) begin
            logic [63:0] d;
            d = '0;
            for (int i = 0; i < 4; i++) d[8*i +: 8] = pat(10, w * 4 + i);
            drive_word(1'b0, d);
        end
        settle("R9");

        // R10: beat appears in the cycle after acceptance
        write_len(4);
        expect_frame(4, 4, 11);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_wide = 1'b0;
        wr_data = {32'h0, pat(11, 3), pat(11, 2), pat(11, 1), pat(11, 0)};
        check(push_valid == 1'b0, "R10", "no beat before edge", push_valid, 0);
        @(posedge clk);
        #1 wr_valid = 1'b0;
        check(push_valid == 1'b1 && push_last == 1'b1, "R10", "beat after edge",
              {push_valid, push_last}, 2'b11);
        settle("R10");

        finish_run();
    end
endmodule